// File: doc/BRIEF.md
# Crosspoint Route Configuration Controller

This block holds and decodes the routing setup for a switch fabric with sixteen inputs and five outputs. A host writes one output's 5-bit route code at a time through a small parallel port. The port has a 3-bit output address, a 5-bit data word, an active-low chip enable and the clock. Each accepted write goes into a staging rank that keeps one slot per output, so one route can change while the other four stay as they are.

A second rank sits between the staging slots and the decoders. It is controlled by a level-sensitive update input. While update is low the second rank follows the staging rank. While update is high it freezes. A host can therefore stage several route changes and make them take effect together by pulling update low. Each output's active code is decoded into a 16-bit one-hot input select and an output-enable bit, and both are registered. An active-low asynchronous reset turns every output off at once. After reset the outputs stay off until new codes are written and passed through.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: A write with chip enable low and address 0 to 4 replaces only the slot of that output. The slots of the other four outputs keep their contents.
- R2: A write to address 5, 6 or 7 changes no slot and no output.
- R3: Chip enable is active low. Clock edges seen while it is high leave every slot unchanged.
- R4: While update is low the second rank follows the staging rank. A write captured at clock edge k appears on the outputs after edge k+1.
- R5: While update is high the outputs hold, even across writes. When update then returns low, the staged codes appear after the next clock edge without any further write.
- R6: In a slot, bits 3:0 give the input index 0 to 15 and bit 4 is the output enable. With the enable set, the select vector of that output has exactly bit `index` set, and its enable output is 1.
- R7: With the enable bit of a slot at 0, that output's select vector is all zeros and its enable output is 0, whatever the index bits hold.
- R8: Reset is asynchronous and active low. Asserting it drives all enables and selects to zero with no clock edge. The outputs then stay off after release until a code is written and passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ceN | input | 1 | Chip enable, active low |
| upd | input | 1 | Second-rank control: low follows, high holds |
| addr | input | 3 | Output address of a write |
| wrData | input | 5 | Route code: bit 4 enable, bits 3:0 input index |
| selOut | output | 80 | Five 16-bit one-hot selects; output n in bits 16n+15:16n |
| enOut | output | 5 | Output enables, bit n for output n |

## Verification
The hardest case to reach from the ports is a difference between the two ranks: the staging slots hold codes that the outputs must not yet show. The bench creates it by raising update, rewriting every output, and checking that nothing moves. It then lowers update with no write in flight and checks that all staged codes appear together. A mismatch at that point can only come from the second rank. Reset is asserted between clock edges, so its effect is seen without a clock.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int N_IN   = 16;
  localparam int N_OUT  = 5;
  localparam int SEL_W  = $clog2(N_IN);
  localparam int SLOT_W = SEL_W + 1;
  localparam int ADDR_W = $clog2(N_OUT);

  typedef struct packed {
    logic [N_OUT-1:0] slotWr;
    logic             latchOpen;
  } strobe_t;
endpackage

// File: rtl/xpt_ctrl.sv
module xpt_ctrl
  import xpt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              upd,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);
  always_comb begin
    stb.latchOpen = !upd;
    for (int i = 0; i < N_OUT; i++) begin
      stb.slotWr[i] = !ceN && (addr == ADDR_W'(i));
    end
  end

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.slotWr)); // R1
  AST_HIGH_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (addr >= ADDR_W'(N_OUT)) |-> (stb.slotWr == '0)); // R2
endmodule

// File: rtl/xpt_decode.sv
module xpt_decode
  import xpt_pkg::*;
(
  input  logic [SLOT_W-1:0] code,
  output logic [N_IN-1:0]   sel,
  output logic              en
);
  always_comb begin
    en  = code[SEL_W];
    sel = '0;
    for (int j = 0; j < N_IN; j++) begin
      sel[j] = en && (code[SEL_W-1:0] == SEL_W'(j));
    end
  end
endmodule

// File: rtl/xpt_datapath.sv
module xpt_datapath
  import xpt_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [SLOT_W-1:0]       wrData,
  output logic [N_OUT*N_IN-1:0]   selOut,
  output logic [N_OUT-1:0]        enOut
);
  logic [N_OUT-1:0][SLOT_W-1:0] rank1, rank1Nxt, hold, view;
  logic [N_OUT-1:0][N_IN-1:0]   selDec, selReg;
  logic [N_OUT-1:0]             enDec;

  always_comb begin
    rank1Nxt = rank1;
    for (int i = 0; i < N_OUT; i++) begin
      if (stb.slotWr[i]) rank1Nxt[i] = wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rank1 <= '0;
      hold  <= '0;
    end else begin
      rank1 <= rank1Nxt;
      if (stb.latchOpen) hold <= rank1Nxt;
    end
  end

  assign view = stb.latchOpen ? rank1 : hold;

  for (genvar g = 0; g < N_OUT; g++) begin : gOut
    xpt_decode uDec (
      .code (view[g]),
      .sel  (selDec[g]),
      .en   (enDec[g])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selReg[g] <= '0;
        enOut[g]  <= 1'b0;
      end else begin
        selReg[g] <= selDec[g];
        enOut[g]  <= enDec[g];
      end
    end

    assign selOut[g*N_IN +: N_IN] = selReg[g];

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(selReg[g]) && (enOut[g] == ($countones(selReg[g]) == 1))); // R6
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      !enOut[g] |-> (selReg[g] == '0)); // R7
    AST_OUT_TRACK: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (enOut[g] == $past(view[g][SEL_W]))); // R4
  end

  AST_NO_STROBE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.slotWr == '0) |=> $stable(rank1)); // R3
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latchOpen |=> $stable(hold)); // R5
endmodule

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl
  import xpt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ceN,
  input  logic                  upd,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [SLOT_W-1:0]     wrData,
  output logic [N_OUT*N_IN-1:0] selOut,
  output logic [N_OUT-1:0]      enOut
);
  strobe_t stb;

  xpt_ctrl uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .ceN  (ceN),
    .upd  (upd),
    .addr (addr),
    .stb  (stb)
  );

  xpt_datapath uPath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .selOut (selOut),
    .enOut  (enOut)
  );

  AST_RST_RELEASE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (enOut == '0)); // R8
endmodule

// File: tb/tb_xpt_cfg_ctrl.sv
module tb_xpt_cfg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NO = 5;
  localparam int NI = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1;
  logic upd = 1'b0;
  logic [2:0] addr = '0;
  logic [4:0] wrData = '0;
  logic [NO*NI-1:0] selOut;
  logic [NO-1:0] enOut;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [4:0] stage [NO];
  logic [4:0] live [NO];

  xpt_cfg_ctrl dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .upd(upd),
    .addr(addr), .wrData(wrData), .selOut(selOut), .enOut(enOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkAll(input string req);
    logic ok;
    ok = 1'b1;
    total++;
    for (int o = 0; o < NO; o++) begin
      logic [NI-1:0] expSel;
      logic expEn;
      expEn  = live[o][4];
      expSel = expEn ? (16'b1 << live[o][3:0]) : 16'b0;
      if (selOut[o*NI +: NI] !== expSel || enOut[o] !== expEn) begin
        ok = 1'b0;
        $display("FAIL %s out%0d: sel=%h en=%b expected sel=%h en=%b",
                 req, o, selOut[o*NI +: NI], enOut[o], expSel, expEn);
      end
    end
    if (!ok) bad++;
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [4:0] d, input logic ce);
    @(negedge clk);
    addr = a; wrData = d; ceN = ce;
    @(negedge clk);
    ceN = 1'b1;
    if (!ce && a < 3'(NO)) stage[a] = d;
    if (!upd) for (int o = 0; o < NO; o++) live[o] = stage[o];
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int o = 0; o < NO; o++) begin stage[o] = '0; live[o] = '0; end
    repeat (3) @(negedge clk);
    checkAll("R8 reset state");
    rstN = 1'b1;
    settle(); settle();
    checkAll("R8 off after release");

    // R6 R7 R1 R4: sweep every code on every output
    for (int o = 0; o < NO; o++) begin
      for (int c = 0; c < 32; c++) begin
        doWrite(3'(o), 5'(c), 1'b0);
        settle();
        checkAll((c < 16) ? "R7 disabled code" : "R6 R1 R4 route write");
      end
    end

    // distinct pattern on all outputs
    for (int o = 0; o < NO; o++) doWrite(3'(o), 5'(16 + 3*o + 1), 1'b0);
    settle();
    checkAll("R1 per-slot independence");

    // R2: high addresses ignored
    for (int a = 5; a < 8; a++) begin
      doWrite(3'(a), 5'h1F, 1'b0);
      settle();
      checkAll("R2 ignored address");
    end

    // R3: chip enable high blocks capture
    for (int o = 0; o < NO; o++) begin
      doWrite(3'(o), 5'h10, 1'b1);
      settle();
      checkAll("R3 chip enable high");
    end

    // R5: hold while update high, then release
    @(negedge clk); upd = 1'b1;
    for (int o = 0; o < NO; o++) doWrite(3'(o), 5'(31 - 2*o), 1'b0);
    settle();
    checkAll("R5 hold while update high");
    doWrite(3'd1, 5'h05, 1'b0);
    settle();
    checkAll("R5 hold across disable write");
    @(negedge clk); upd = 1'b0;
    for (int o = 0; o < NO; o++) live[o] = stage[o];
    settle();
    checkAll("R5 staged codes released");

    // R8: asynchronous reset between edges
    @(negedge clk);
    #1 rstN = 1'b0;
    for (int o = 0; o < NO; o++) begin stage[o] = '0; live[o] = '0; end
    #1 checkAll("R8 async clear");
    @(negedge clk); rstN = 1'b1;
    settle(); settle();
    checkAll("R8 stays off after release");
    doWrite(3'd4, 5'h1A, 1'b0);
    settle();
    checkAll("R8 R4 write after reset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule